// File: doc/BRIEF.md
# Segmented Page-Table Translation Unit

This unit translates 32-bit virtual addresses under a scheme that mixes segmentation with paging, using 4 KB pages. The two most significant address bits name a segment. Code, heap and stack each own a private linear page table, and every table is described by a base (the physical address of the table) and a bound (the number of pages the table maps). Encoding 00 names no segment. For an incoming address, the unit picks the segment's pair and checks the page number against the bound. Only a page number inside the bound causes a read of the page-table word at `base + 4*page`. The unit then returns either the physical address or a fault with its cause.

The request is accepted when `req_ready` is high. A single-cycle `mem_req` pulse carries the table-word address to memory. Memory answers later with `mem_rvalid`. The result appears as a one-cycle `resp_valid` pulse. A write port reloads any of the three base/bound pairs, so the tables of a newly scheduled process can be installed on a context switch.

Top module: `segx_pt_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req` are 0. Every base and bound resets to 0, so any access faults with cause BOUND until the pair is configured.
- R2: An address whose bits [31:30] are 00 gives a response with `resp_cause` = 1 (SEG) and issues no memory read.
- R3: A page number (bits [29:12]) greater than or equal to the selected segment's bound gives `resp_cause` = 2 (BOUND) and issues no memory read.
- R4: An in-bound access issues exactly one one-cycle `mem_req` whose `mem_addr` is the selected segment's base plus page number times 4. Segment 01 selects code, 10 selects heap and 11 selects stack.
- R5: If the returned table word has bit 0 set, the response has `resp_fault` = 0, `resp_cause` = 0 and `resp_paddr` = {word[31:12], vaddr[11:0]}.
- R6: If the returned table word has bit 0 clear, the response has `resp_cause` = 3 (INVALID). On every fault, `resp_fault` = 1 and `resp_paddr` = 0.
- R7: A write with `cfg_we`=1 loads `cfg_wdata` into the base (`cfg_field`=0) or the bound (`cfg_field`=1, low 19 bits) of the segment named by `cfg_seg`. A write with `cfg_seg`=00 changes nothing.
- R8: A configuration write made after a request is accepted does not change that request's table-word address or result.
- R9: `req_ready` stays 0 from acceptance until the response. `resp_valid` is high for exactly one cycle, and `req_ready` is back to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seg | input | 2 | Segment whose pair is written (00 ignored) |
| cfg_field | input | 1 | 0 = base, 1 = bound |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| mem_req | output | 1 | One-cycle table-word read pulse |
| mem_addr | output | 32 | Table-word physical address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Translation faulted |
| resp_cause | output | 2 | 0 none, 1 SEG, 2 BOUND, 3 INVALID |
| resp_paddr | output | 32 | Physical address, 0 on fault |

## Verification
The bench uses the default parameters: 32-bit addresses, 12 offset bits, 2 segment bits and 4-byte table words, which gives 18-bit page numbers and 19-bit bounds. With these values, a page number of 0x3FFFF lies within reach as a bound-edge case. The page-equals-bound edge is reachable with small bounds (3 and 1). Tables can be placed in a 1 KB memory model answering after two cycles, which opens a window in which a configuration write lands mid-walk.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_SEG     = 2'd1,
    FLT_BOUND   = 2'd2,
    FLT_INVALID = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/segx_regfile.sv
module segx_regfile #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 2,
  parameter int BOUND_W  = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_seg,
  input  logic                cfg_field,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  input  logic [SEG_BITS-1:0] rd_seg,
  output logic [ADDR_W-1:0]   rd_base,
  output logic [BOUND_W-1:0]  rd_bound
);
  localparam int NSLOT = 1 << SEG_BITS;

  logic [NSLOT*ADDR_W-1:0]  base_flat;
  logic [NSLOT*BOUND_W-1:0] bound_flat;

  assign base_flat[ADDR_W-1:0]   = '0;
  assign bound_flat[BOUND_W-1:0] = '0;

  for (genvar g = 1; g < NSLOT; g++) begin : g_seg
    logic [ADDR_W-1:0]  base_q,  base_d;
    logic [BOUND_W-1:0] bound_q, bound_d;
    logic               base_en, bound_en;

    always_comb begin
      base_en  = cfg_we && (cfg_seg == SEG_BITS'(g)) && !cfg_field;
      bound_en = cfg_we && (cfg_seg == SEG_BITS'(g)) &&  cfg_field;
      base_d   = base_en  ? cfg_wdata : base_q;
      bound_d  = bound_en ? cfg_wdata[BOUND_W-1:0] : bound_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        bound_q <= '0;
      end else begin
        base_q  <= base_d;
        bound_q <= bound_d;
      end
    end

    assign base_flat[g*ADDR_W +: ADDR_W]    = base_q;
    assign bound_flat[g*BOUND_W +: BOUND_W] = bound_q;
  end

  assign rd_base  = base_flat[rd_seg*ADDR_W +: ADDR_W];
  assign rd_bound = bound_flat[rd_seg*BOUND_W +: BOUND_W];
endmodule

// File: rtl/segx_decode.sv
module segx_decode
  import segx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_BITS  = 2,
  parameter int PTE_SHIFT = 2,
  parameter int BOUND_W   = 19
) (
  input  logic [ADDR_W-1:0]    vaddr,
  input  logic [ADDR_W-1:0]    seg_base,
  input  logic [BOUND_W-1:0]   seg_bound,
  output logic [SEG_BITS-1:0]  seg,
  output logic [PAGE_BITS-1:0] offset,
  output logic [ADDR_W-1:0]    pte_addr,
  output fault_e               early_fault
);
  localparam int VPN_W = ADDR_W - PAGE_BITS - SEG_BITS;

  logic [VPN_W-1:0] vpn;

  always_comb begin
    seg      = vaddr[ADDR_W-1 -: SEG_BITS];
    vpn      = vaddr[PAGE_BITS +: VPN_W];
    offset   = vaddr[PAGE_BITS-1:0];
    pte_addr = seg_base + (ADDR_W'(vpn) << PTE_SHIFT);
    if (seg == '0)
      early_fault = FLT_SEG;
    else if (BOUND_W'(vpn) >= seg_bound)
      early_fault = FLT_BOUND;
    else
      early_fault = FLT_NONE;
  end
endmodule

// File: rtl/segx_walk.sv
module segx_walk
  import segx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  fault_e               early_fault,
  input  logic [ADDR_W-1:0]    pte_addr,
  input  logic [PAGE_BITS-1:0] offset,
  output logic                 req_ready,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [ADDR_W-1:0]    mem_rdata,
  output logic                 resp_valid,
  output logic                 resp_fault,
  output logic [1:0]           resp_cause,
  output logic [ADDR_W-1:0]    resp_paddr
);
  localparam int FRAME_W = ADDR_W - PAGE_BITS;

  walk_state_e          state_q, state_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [PAGE_BITS-1:0] off_q, off_d;
  fault_e               cause_q, cause_d;
  logic [ADDR_W-1:0]    paddr_q, paddr_d;
  logic                 accept;
  logic [FRAME_W-1:0]   frame;
  logic                 entry_ok;

  assign frame    = mem_rdata[ADDR_W-1 -: FRAME_W];
  assign entry_ok = mem_rdata[0];
  assign accept   = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    off_d   = off_q;
    cause_d = cause_q;
    paddr_d = paddr_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        addr_d = pte_addr;
        off_d  = offset;
        if (early_fault != FLT_NONE) begin
          cause_d = early_fault;
          paddr_d = '0;
          state_d = ST_RESP;
        end else begin
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        state_d = ST_RESP;
        if (entry_ok) begin
          cause_d = FLT_NONE;
          paddr_d = {frame, off_q};
        end else begin
          cause_d = FLT_INVALID;
          paddr_d = '0;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      cause_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      off_q   <= off_d;
      cause_q <= cause_d;
      paddr_q <= paddr_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_ISSUE);
  assign mem_addr   = addr_q;
  assign resp_valid = (state_q == ST_RESP);
  assign resp_fault = (cause_q != FLT_NONE);
  assign resp_cause = cause_q;
  assign resp_paddr = paddr_q;
endmodule

// File: rtl/segx_pt_unit.sv
module segx_pt_unit
  import segx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_BITS  = 2,
  parameter int PTE_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_seg,
  input  logic                cfg_field,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_vaddr,
  output logic                req_ready,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [ADDR_W-1:0]   mem_rdata,
  output logic                resp_valid,
  output logic                resp_fault,
  output logic [1:0]          resp_cause,
  output logic [ADDR_W-1:0]   resp_paddr
);
  localparam int VPN_W     = ADDR_W - PAGE_BITS - SEG_BITS;
  localparam int BOUND_W   = VPN_W + 1;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  logic [SEG_BITS-1:0]  seg;
  logic [ADDR_W-1:0]    seg_base;
  logic [BOUND_W-1:0]   seg_bound;
  logic [PAGE_BITS-1:0] offset;
  logic [ADDR_W-1:0]    pte_addr;
  fault_e               early_fault;

  segx_regfile #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .BOUND_W(BOUND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .rd_seg(seg),
    .rd_base(seg_base), .rd_bound(seg_bound)
  );

  segx_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SEG_BITS(SEG_BITS),
                .PTE_SHIFT(PTE_SHIFT), .BOUND_W(BOUND_W)) u_dec (
    .vaddr(req_vaddr), .seg_base(seg_base), .seg_bound(seg_bound),
    .seg(seg), .offset(offset), .pte_addr(pte_addr), .early_fault(early_fault)
  );

  segx_walk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .early_fault(early_fault),
    .pte_addr(pte_addr), .offset(offset), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_cause(resp_cause), .resp_paddr(resp_paddr)
  );
endmodule

// File: rtl/segx_pt_checker.sv
module segx_pt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              mem_req,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic [1:0]        resp_cause,
  input logic [ADDR_W-1:0] resp_paddr
);
  logic take;
  assign take = req_valid && req_ready;

  p_unused_seg_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && (req_vaddr[ADDR_W-1 -: 2] == 2'b00) |=> resp_valid && (resp_cause == 2'd1));

  p_unused_seg_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && (req_vaddr[ADDR_W-1 -: 2] == 2'b00) |=> !mem_req);

  p_single_read_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_accept_leads_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mem_req || resp_valid);

  p_fault_zero_paddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_resp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);
endmodule

bind segx_pt_unit segx_pt_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_segx_pt_unit.sv
`timescale 1ns/1ps
module tb_segx_pt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_seg;
  logic        cfg_field;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        resp_valid;
  logic        resp_fault;
  logic [1:0]  resp_cause;
  logic [31:0] resp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  int n_reads = 0;
  int cycles = 0;
  logic [31:0] last_addr;

  logic [31:0] ptmem [0:255];
  logic        pend;
  int          lat;
  logic [31:0] pend_addr;

  always #2.5 clk = ~clk;

  segx_pt_unit dut (.*);

  // memory model: answers two cycles after the read pulse
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      n_reads   <= n_reads + 1;
      last_addr <= mem_addr;
      pend      <= 1'b1;
      pend_addr <= mem_addr;
      lat       <= 2;
    end else if (pend) begin
      if (lat == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ptmem[pend_addr[9:2]];
        pend       <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] s, logic f, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] va(logic [1:0] s, logic [17:0] p, logic [11:0] o);
    return {s, p, o};
  endfunction

  // one translation; checks cause, paddr, read count and table-word address
  task automatic xlate(string tag, logic [31:0] v, logic [1:0] ecause,
                       logic [31:0] epaddr, int ereads, logic [31:0] eaddr);
    int r0;
    int waitc;
    @(negedge clk);
    r0 = n_reads;
    req_valid = 1'b1; req_vaddr = v;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!resp_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    chk({tag, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " cause"}, 32'(resp_cause), 32'(ecause));
    chk({tag, " fault"}, 32'(resp_fault), 32'(ecause != 2'd0));
    chk({tag, " paddr"}, resp_paddr, epaddr);
    chk({tag, " reads"}, 32'(n_reads - r0), 32'(ereads));
    if (ereads != 0) chk({tag, " mem_addr"}, last_addr, eaddr);
    @(negedge clk);
    chk({tag, " resp one cycle (R9)"}, 32'(resp_valid), 32'd0);
    chk({tag, " ready back (R9)"}, 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    xlate("R1 unconfigured code bound", va(2'b01, 18'd0, 12'h0), 2'd2, 32'h0, 0, 32'h0);
  endtask

  task automatic t_setup;
    cfg_write(2'b01, 1'b0, 32'h100); cfg_write(2'b01, 1'b1, 32'd3);
    cfg_write(2'b10, 1'b0, 32'h200); cfg_write(2'b10, 1'b1, 32'd2);
    cfg_write(2'b11, 1'b0, 32'h300); cfg_write(2'b11, 1'b1, 32'd4);
  endtask

  task automatic t_hits;
    xlate("R4 R5 code vpn1", va(2'b01, 18'd1, 12'h123), 2'd0, 32'h0001_7123, 1, 32'h104);
    xlate("R4 R5 heap vpn0", va(2'b10, 18'd0, 12'hFFF), 2'd0, 32'h0002_3FFF, 1, 32'h200);
    xlate("R4 R5 stack vpn3", va(2'b11, 18'd3, 12'h000), 2'd0, 32'h0001_C000, 1, 32'h30C);
  endtask

  task automatic t_faults;
    xlate("R6 invalid entry", va(2'b01, 18'd2, 12'h0AB), 2'd3, 32'h0, 1, 32'h108);
    xlate("R2 unused segment", va(2'b00, 18'd1, 12'h010), 2'd1, 32'h0, 0, 32'h0);
    xlate("R3 vpn equals bound", va(2'b01, 18'd3, 12'h000), 2'd2, 32'h0, 0, 32'h0);
    xlate("R3 vpn max", va(2'b11, 18'h3FFFF, 12'h7), 2'd2, 32'h0, 0, 32'h0);
  endtask

  task automatic t_config;
    cfg_write(2'b00, 1'b0, 32'h0);
    cfg_write(2'b00, 1'b1, 32'h0);
    xlate("R7 seg00 write ignored code", va(2'b01, 18'd0, 12'h001), 2'd0, 32'h0000_A001, 1, 32'h100);
    xlate("R7 seg00 write ignored heap", va(2'b10, 18'd1, 12'h002), 2'd0, 32'h0002_4002, 1, 32'h204);
    cfg_write(2'b10, 1'b1, 32'd0);
    xlate("R7 heap bound zero", va(2'b10, 18'd0, 12'h0), 2'd2, 32'h0, 0, 32'h0);
    cfg_write(2'b10, 1'b1, 32'd2);
    cfg_write(2'b01, 1'b0, 32'h180); cfg_write(2'b01, 1'b1, 32'd1);
    xlate("R7 switched code vpn0", va(2'b01, 18'd0, 12'h456), 2'd0, 32'h0009_9456, 1, 32'h180);
    xlate("R7 switched code vpn1 bound", va(2'b01, 18'd1, 12'h0), 2'd2, 32'h0, 0, 32'h0);
    xlate("R4 stack unaffected", va(2'b11, 18'd0, 12'h010), 2'd0, 32'h0003_3010, 1, 32'h300);
  endtask

  // R8 and R9: write config during a walk; hold request while busy
  task automatic t_midwalk;
    int r0;
    int waitc;
    @(negedge clk);
    r0 = n_reads;
    req_valid = 1'b1; req_vaddr = va(2'b10, 18'd1, 12'h0C0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 not ready after accept", 32'(req_ready), 32'd0);
    cfg_we = 1'b1; cfg_seg = 2'b10; cfg_field = 1'b0; cfg_wdata = 32'h380;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 not ready while walking", 32'(req_ready), 32'd0);
    waitc = 0;
    while (!resp_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    chk("R8 inflight paddr", resp_paddr, 32'h0002_40C0);
    chk("R8 inflight addr", last_addr, 32'h204);
    chk("R8 one read", 32'(n_reads - r0), 32'd1);
    @(negedge clk);
    xlate("R7 new heap base used", va(2'b10, 18'd1, 12'h0C0), 2'd0, 32'h0007_70C0, 1, 32'h384);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ptmem[i] = 32'h0;
    ptmem[8'h40] = 32'h0000_A001;
    ptmem[8'h41] = 32'h0001_7001;
    ptmem[8'h42] = 32'h0005_5000;
    ptmem[8'h60] = 32'h0009_9001;
    ptmem[8'h80] = 32'h0002_3001;
    ptmem[8'h81] = 32'h0002_4001;
    ptmem[8'hC0] = 32'h0003_3001;
    ptmem[8'hC3] = 32'h0001_C001;
    ptmem[8'hE1] = 32'h0007_7001;
    pend = 1'b0; lat = 0; pend_addr = '0; last_addr = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    cfg_we = 1'b0; cfg_seg = '0; cfg_field = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_hits;
    t_faults;
    t_config;
    t_midwalk;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule